// File: doc/BRIEF.md
# Bus-Mapped Watchdog Timer with Reset Pulse Generator

A watchdog for a 32-bit register bus. A down-counter is loaded from a programmable reload value and decremented on a tick. The control word selects the tick: every peripheral clock cycle, or once per `PCLK_HZ/TICK_HZ` cycles to give a 1 MHz rate. If software fails to write the 16-bit restart key before the counter runs out, the block ends the countdown. When enabled in the control word, it then drives a system-reset pulse, raises a one-cycle timeout flag, or both.

The width of the reset pulse, its asserted level and the pad drive type come from a reset-width register. The level and drive-type bits change only when one of four codes is written into the top byte. A sideband inhibit input, held high while the memory controller is being reset, turns an expiry into a silent disable. Control writes are filtered so that only a change of the enable bit is accepted.

Top module: `wdog_ctl`

## Requirements
- R1: After reset, the live count and the reload value read 0x03EF1480, control reads 0, the reset-width register reads 0x000000FF, `rst_pulse_o` is high (idle level for active-low), and `push_pull_o` and `timeout_o` are low.
- R2: Byte offsets are 0x00 live count (read-only), 0x04 reload, 0x08 restart (write-only), 0x0C control and 0x18 reset width. Reads of 0x08 and of every other offset return 0. Writes to 0x00 and to unmapped offsets change nothing.
- R3: A control write is stored only if its bit 0 (enable) differs from the stored enable. A 0-to-1 change loads the counter from the reload value and starts counting. A 1-to-0 change stops counting with the count frozen.
- R4: A write to 0x08 whose low 16 bits equal 0x4755 reloads the counter and restarts the countdown while enable is set. Any other value, or any write while enable is clear, leaves the count unchanged.
- R5: Control bit 4 = 0 decrements the count once per clock. Bit 4 = 1 decrements it once per `PCLK_HZ/TICK_HZ` clocks. The tick that finds the count at zero is the expiry, so expiry falls (reload+1) ticks after the load.
- R6: On expiry with inhibit low, counting stops. If control bit 1 is set, `rst_pulse_o` takes its asserted level for exactly width-field (bits 19:0) cycles. If control bit 2 is set, `timeout_o` is high for one cycle.
- R7: On expiry with `inhibit_i` high, the whole control register clears to 0, and neither the reset pulse nor the timeout flag appears.
- R8: A reset-width write with top byte 0xA5 sets bit 31 (active-high pulse), 0x5A clears it, 0xA8 sets bit 30 (push-pull) and 0x8A clears it. Any other top byte leaves bits 31:30 unchanged. Every write loads bits 19:0, and bits 29:20 read 0.
- R9: `push_pull_o` follows bit 30 of the reset-width register. `rst_pulse_o` idles at the inverse of bit 31.
- R10: When a valid restart and an expiry fall in the same cycle, the restart wins: no pulse or flag is produced, and the count reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 5 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| inhibit_i | input | 1 | Memory-reset inhibit; turns expiry into a disable |
| rst_pulse_o | output | 1 | System-reset pulse at the programmed level |
| push_pull_o | output | 1 | Drive-type flag for the pad (1 = push-pull) |
| timeout_o | output | 1 | One-cycle flag on expiry |

## Verification
On every cycle, the assertions check these rules:
- The control register moves only on an accepted enable change or an inhibited expiry.
- A restart loads the reload value.
- Each tick takes exactly one from a non-zero count.
- Counting halts after expiry.
- The timeout flag never lasts two cycles.
- The polarity code sets its bit.

Only the bench scenarios can show the end-to-end cycle counts: expiry at (reload+1) ticks under both tick sources, and the exact pulse length at both polarities. The same holds for the same-cycle race between restart and expiry, the zero reads of write-only and unmapped offsets, and the silent disable under inhibit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_KICK   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_WIDTH  = 5'h18;

  localparam logic [15:0] KICK_KEY = 16'h4755;

  localparam logic [7:0] CODE_HIGH = 8'hA5;
  localparam logic [7:0] CODE_LOW  = 8'h5A;
  localparam logic [7:0] CODE_PP   = 8'hA8;
  localparam logic [7:0] CODE_OD   = 8'h8A;

  localparam logic [DW-1:0] RST_COUNT = 32'h03EF1480;
  localparam logic [7:0]    RST_WIDTH = 8'hFF;

  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_SLOW = 4;

  typedef struct packed {
    logic load;
    logic stop;
  } cnt_cmd_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned PW = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     cnt_i,
  input  logic              clr_i,
  output cnt_cmd_t          cmd_o,
  output logic [DW-1:0]     reload_o,
  output logic              slow_o,
  output logic              rst_en_o,
  output logic              irq_en_o,
  output logic [PW-1:0]     width_o,
  output logic              high_o,
  output logic              pp_o
);
  localparam int unsigned GAP = DW - 2 - PW;

  logic [DW-1:0] ctrl_q, reload_q;
  logic [PW-1:0] width_q;
  logic          high_q, pp_q;

  logic wr, ctrl_acc, kick_ok, wid_wr;
  logic [7:0] code;

  assign wr       = req_i & we_i;
  assign ctrl_acc = wr && addr_i == OFS_CTRL && (wdata_i[CB_EN] != ctrl_q[CB_EN]);
  assign kick_ok  = wr && addr_i == OFS_KICK && wdata_i[15:0] == KICK_KEY && ctrl_q[CB_EN];
  assign wid_wr   = wr && addr_i == OFS_WIDTH;
  assign code     = wdata_i[DW-1 -: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= RST_COUNT;
      width_q  <= PW'(RST_WIDTH);
      high_q   <= 1'b0;
      pp_q     <= 1'b0;
    end else begin
      if (clr_i)         ctrl_q <= '0;
      else if (ctrl_acc) ctrl_q <= wdata_i;
      if (wr && addr_i == OFS_RELOAD) reload_q <= wdata_i;
      if (wid_wr) begin
        width_q <= wdata_i[PW-1:0];
        case (code)
          CODE_HIGH: high_q <= 1'b1;
          CODE_LOW:  high_q <= 1'b0;
          CODE_PP:   pp_q   <= 1'b1;
          CODE_OD:   pp_q   <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      OFS_COUNT:  rdata_o = cnt_i;
      OFS_RELOAD: rdata_o = reload_q;
      OFS_CTRL:   rdata_o = ctrl_q;
      OFS_WIDTH:  rdata_o = {high_q, pp_q, {GAP{1'b0}}, width_q};
      default:    rdata_o = '0;
    endcase
  end

  assign cmd_o.load = kick_ok | (ctrl_acc & wdata_i[CB_EN]);
  assign cmd_o.stop = ctrl_acc & ~wdata_i[CB_EN];
  assign reload_o   = reload_q;
  assign slow_o     = ctrl_q[CB_SLOW];
  assign rst_en_o   = ctrl_q[CB_RST];
  assign irq_en_o   = ctrl_q[CB_IRQ];
  assign width_o    = width_q;
  assign high_o     = high_q;
  assign pp_o       = pp_q;

  assert_ctrl_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q != $past(ctrl_q)) |->
      ($past(clr_i) || ($past(wr) && $past(addr_i) == OFS_CTRL &&
                        $past(wdata_i[CB_EN]) != $past(ctrl_q[CB_EN]))));

  assert_inhibit_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ctrl_q == '0);

  assert_high_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_wr && code == CODE_HIGH) |=> high_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned DIV = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cnt_cmd_t      cmd_i,
  input  logic          slow_i,
  input  logic [DW-1:0] reload_i,
  output logic [DW-1:0] cnt_o,
  output logic          expire_o
);
  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(DIV - 1);

  logic [DW-1:0]    cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             run_q, tick;

  assign tick     = slow_i ? (pre_q == '0) : 1'b1;
  assign expire_o = run_q & tick & (cnt_q == '0) & ~cmd_i.load & ~cmd_i.stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_COUNT;
      pre_q <= PRE_TOP;
      run_q <= 1'b0;
    end else if (cmd_i.load) begin
      cnt_q <= reload_i;
      pre_q <= PRE_TOP;
      run_q <= 1'b1;
    end else if (cmd_i.stop) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (tick) begin
        pre_q <= PRE_TOP;
        if (cnt_q == '0) run_q <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;

  assert_kick_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.load |=> (cnt_o == $past(reload_i)) && run_q);

  assert_decrement_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick && cnt_q != '0 && !cmd_i.load && !cmd_i.stop) |=>
      cnt_q == $past(cnt_q) - 1'b1);

  assert_halt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !run_q);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          rst_en_i,
  input  logic          irq_en_i,
  input  logic [PW-1:0] width_i,
  input  logic          high_i,
  output logic          pulse_o,
  output logic          timeout_o
);
  logic [PW-1:0] left_q;
  logic          to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      to_q   <= 1'b0;
    end else begin
      to_q <= fire_i & irq_en_i;
      if (fire_i && rst_en_i) left_q <= width_i;
      else if (left_q != '0)  left_q <= left_q - 1'b1;
    end
  end

  assign pulse_o   = (left_q != '0) ? high_i : ~high_i;
  assign timeout_o = to_q;

  assert_timeout_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  assert_pulse_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && rst_en_i && width_i != '0) |=> (pulse_o == high_i));
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter int unsigned PCLK_HZ = 24_000_000,
  parameter int unsigned TICK_HZ = 1_000_000,
  parameter int unsigned PW      = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              inhibit_i,
  output logic              rst_pulse_o,
  output logic              push_pull_o,
  output logic              timeout_o
);
  localparam int unsigned DIV = PCLK_HZ / TICK_HZ;

  cnt_cmd_t      cmd;
  logic [DW-1:0] cnt, reload;
  logic [PW-1:0] width;
  logic          slow, rst_en, irq_en, high, expire;

  wdog_regs #(.PW(PW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .clr_i(expire & inhibit_i), .cmd_o(cmd), .reload_o(reload),
    .slow_o(slow), .rst_en_o(rst_en), .irq_en_o(irq_en), .width_o(width),
    .high_o(high), .pp_o(push_pull_o)
  );

  wdog_counter #(.DIV(DIV)) u_cnt (
    .clk_i, .rst_ni, .cmd_i(cmd), .slow_i(slow), .reload_i(reload),
    .cnt_o(cnt), .expire_o(expire)
  );

  wdog_pulse #(.PW(PW)) u_pulse (
    .clk_i, .rst_ni, .fire_i(expire & ~inhibit_i), .rst_en_i(rst_en),
    .irq_en_i(irq_en), .width_i(width), .high_i(high),
    .pulse_o(rst_pulse_o), .timeout_o
  );
endmodule

// File: tb/sim_wdog_ctl.sv
module sim_wdog_ctl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, inhibit_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rst_pulse_o, push_pull_o, timeout_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  wdog_ctl u0 (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .inhibit_i, .rst_pulse_o, .push_pull_o, .timeout_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = 1'b0; inhibit_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(5'h00, d); chk("R1 count", d, 32'h03EF1480);
    rd(5'h04, d); chk("R1 reload", d, 32'h03EF1480);
    rd(5'h0C, d); chk("R1 ctrl", d, 0);
    rd(5'h18, d); chk("R1 width", d, 32'hFF);
    chk("R1 pulse idle", rst_pulse_o, 1);
    chk("R1 pp", push_pull_o, 0);
    chk("R1 timeout", timeout_o, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    do_reset();
    wr(5'h04, 32'h1234); rd(5'h04, d); chk("R2 reload rw", d, 32'h1234);
    wr(5'h00, 32'h55);   rd(5'h00, d); chk("R2 count ro", d, 32'h03EF1480);
    wr(5'h10, 32'hFFFF); rd(5'h10, d); chk("R2 rsvd 10", d, 0);
    rd(5'h08, d); chk("R2 kick reads 0", d, 0);
    rd(5'h14, d); chk("R2 rsvd 14", d, 0);
    rd(5'h1C, d); chk("R2 unmapped", d, 0);
  endtask

  task automatic t_ctrl_gate();
    logic [31:0] d;
    do_reset();
    wr(5'h0C, 32'h6);  rd(5'h0C, d); chk("R3 no-change dropped", d, 0);
    wr(5'h0C, 32'h21); rd(5'h0C, d); chk("R3 enable stored", d, 32'h21);
    wr(5'h0C, 32'h3F); rd(5'h0C, d); chk("R3 still enabled dropped", d, 32'h21);
    wr(5'h0C, 32'h20); rd(5'h0C, d); chk("R3 disable stored", d, 32'h20);
  endtask

  task automatic t_kick();
    logic [31:0] d, e;
    do_reset();
    wr(5'h04, 32'd100);
    wr(5'h0C, 32'h1);
    rd(5'h00, d); chk("R3 load on enable", d, 100);
    repeat (10) @(negedge clk_i);
    rd(5'h00, d); chk("R5 per-clock decrement", d, 90);
    wr(5'h08, 32'h4756); rd(5'h00, d); chk("R4 wrong key ignored", d, 89);
    wr(5'h08, 32'hFFFF4755); rd(5'h00, d); chk("R4 key reloads", d, 100);
    wr(5'h0C, 32'h0); rd(5'h00, d); chk("R3 stop freezes", d, 100);
    repeat (5) @(negedge clk_i);
    rd(5'h00, e); chk("R3 stays frozen", e, 100);
    wr(5'h04, 32'd50);
    wr(5'h08, 32'h4755); rd(5'h00, d); chk("R4 key ignored when disabled", d, 100);
  endtask

  task automatic t_expire_fast();
    int first = 0, low = 0, tos = 0, tok = 0;
    logic [31:0] d;
    do_reset();
    wr(5'h18, 32'h3);
    wr(5'h04, 32'd5);
    wr(5'h0C, 32'h7);
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk_i);
      if (rst_pulse_o == 1'b0) begin low++; if (first == 0) first = k; end
      if (timeout_o) begin tos++; tok = k; end
    end
    chk("R5 expiry after reload+1 clocks", first, 6);
    chk("R6 active-low width", low, 3);
    chk("R6 timeout count", tos, 1);
    chk("R6 timeout cycle", tok, 6);
    rd(5'h00, d); chk("R6 counting stopped", d, 0);
  endtask

  task automatic t_expire_slow();
    int first = 0, hi = 0;
    do_reset();
    wr(5'h18, 32'hA5000002);
    chk("R9 idle low when active-high", rst_pulse_o, 0);
    wr(5'h04, 32'd1);
    wr(5'h0C, 32'h13);
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk_i);
      if (rst_pulse_o) begin hi++; if (first == 0) first = k; end
      chk("R6 no timeout when irq clear", timeout_o, 0);
    end
    chk("R5 slow tick expiry", first, 48);
    chk("R6 active-high width", hi, 2);
  endtask

  task automatic t_inhibit();
    int hits = 0;
    logic [31:0] d;
    do_reset();
    inhibit_i = 1'b1;
    wr(5'h04, 32'd2);
    wr(5'h0C, 32'h7);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk_i);
      if (!rst_pulse_o || timeout_o) hits++;
    end
    chk("R7 no pulse or flag", hits, 0);
    rd(5'h0C, d); chk("R7 ctrl cleared", d, 0);
    inhibit_i = 1'b0;
  endtask

  task automatic t_width();
    logic [31:0] d;
    do_reset();
    wr(5'h18, 32'hA5000003); rd(5'h18, d); chk("R8 high code", d, 32'h80000003);
    wr(5'h18, 32'hA8000010); rd(5'h18, d); chk("R8 pp code", d, 32'hC0000010);
    chk("R9 pp out", push_pull_o, 1);
    wr(5'h18, 32'h5A000004); rd(5'h18, d); chk("R8 low code", d, 32'h40000004);
    wr(5'h18, 32'h12F00005); rd(5'h18, d); chk("R8 other code", d, 32'h40000005);
    wr(5'h18, 32'h8A000003); rd(5'h18, d); chk("R8 od code", d, 32'h00000003);
    chk("R9 od out", push_pull_o, 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    do_reset();
    wr(5'h18, 32'h4);
    wr(5'h04, 32'd2);
    wr(5'h0C, 32'h7);
    repeat (2) @(negedge clk_i);
    wr(5'h08, 32'h4755);
    chk("R10 no pulse on race", rst_pulse_o, 1);
    chk("R10 no flag on race", timeout_o, 0);
    rd(5'h00, d); chk("R10 count reloaded", d, 2);
    repeat (2) @(negedge clk_i);
    chk("R10 not yet expired", rst_pulse_o, 1);
    @(negedge clk_i);
    chk("R10 later expiry", rst_pulse_o, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    t_reset();
    t_regmap();
    t_ctrl_gate();
    t_kick();
    t_expire_fast();
    t_expire_slow();
    t_inhibit();
    t_width();
    t_race();
    finish_run();
  end
endmodule